// File: doc/BRIEF.md
# SPI FIFO Word Packer and Unpacker

This block links a byte stream to the 32-bit slot interface of an SPI shift engine. On the transmit side it collects 1, 2 or 4 bytes into each FIFO word, with the first byte at the most significant end. Because the shifter sends the most significant bits first, word 0xAABBCCDD leaves the wire as AA, BB, CC, DD. On the receive side it splits each FIFO word into bytes, with the bytes right-aligned in the slot. A transfer begins with a start pulse, which latches the word-size mode and the transmit and receive byte lengths. The block then handles `N = ceil(max(tx_len, rx_len) / word_bytes)` words in each direction. When the transmit data ends first, the block pads the missing positions with zeros, so the clock keeps running while receive data is still being collected. When the receive length ends first, the block takes the extra words from the FIFO but does not pass their bytes on.

The top controller has two states. In TOP_IDLE a start pulse moves it to TOP_RUN. It returns to TOP_IDLE in the cycle where both datapaths are idle, and raises `done` for that one cycle. The transmit packer has three states:
- TXS_IDLE goes to TXS_GATHER on start if N > 0.
- TXS_GATHER goes to TXS_EMIT when the last slot of the word is filled, or when no transmit bytes remain.
- TXS_EMIT, on acceptance of the word, goes back to TXS_GATHER, or to TXS_IDLE after word N.

The receive unpacker also has three states:
- RXS_IDLE goes to RXS_WAIT on start if N > 0.
- RXS_WAIT goes to RXS_DRAIN when a word is accepted.
- RXS_DRAIN goes back to RXS_WAIT, or to RXS_IDLE after word N. It leaves after the last slot's byte is taken, or at once when the receive length is used up.

Top module: `spi_word_packer`

## Requirements
- R1: The word size follows `cfg_wmode`:
  - 0 selects 1 byte, 1 selects 2 bytes and 2 selects 4 bytes.
  - 3 (automatic) selects 4 bytes when `cfg_tx_len` is nonzero and a multiple of 4, and 1 byte otherwise.
- R2: `bpw_code` is 8 × word bytes − 1 (7, 15 or 31). It updates at the start edge and resets to 7.
- R3: In a transmit word, byte k of the word (k = 0 first) sits in bits [31−8k −: 8]. Bits below the word size are zero.
- R4: Exactly N transmit words are emitted. Any byte position past `tx_len` holds zero, including whole filler words.
- R5: For a word of W bytes, received byte k (k = 0 first) comes from bits [8(W−1−k) +: 8]. This gives [7:0] for 1-byte words, [15:8] then [7:0] for 2-byte words, and [31:24] down to [7:0] for 4-byte words.
- R6: Exactly N receive words are accepted. Only the first `rx_len` bytes appear on the byte output, and the rest are dropped.
- R7: The configuration is latched at an accepted start. While a transfer is running, changes to the configuration inputs and further start pulses have no effect.
- R8: `tx_count` and `rx_count` count the bytes packed and the bytes stored. Both clear at each accepted start.
- R9: `done` is a single-cycle pulse in the cycle after the last word in both directions. With N = 0 it comes in the cycle after start.
- R10: Once `tx_word_valid` or `rx_byte_valid` is raised, it stays high with stable data until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| cfg_wmode | input | 2 | Word-size mode (0:1B, 1:2B, 2:4B, 3:auto) |
| cfg_tx_len | input | LEN_W | Transmit byte length |
| cfg_rx_len | input | LEN_W | Receive byte length |
| tx_byte_valid | input | 1 | Transmit byte offered |
| tx_byte_data | input | 8 | Transmit byte |
| tx_byte_ready | output | 1 | Transmit byte taken |
| tx_word_valid | output | 1 | Packed word offered to FIFO |
| tx_word_data | output | WORD_W | Packed word |
| tx_word_ready | input | 1 | FIFO accepts the word |
| rx_word_valid | input | 1 | Received FIFO word offered |
| rx_word_data | input | WORD_W | Received FIFO word |
| rx_word_ready | output | 1 | Received word taken |
| rx_byte_valid | output | 1 | Unpacked byte offered |
| rx_byte_data | output | 8 | Unpacked byte |
| rx_byte_ready | input | 1 | Byte sink accepts the byte |
| bpw_code | output | BPW_W | Bits-per-word code for the shifter |
| tx_count | output | LEN_W | Bytes packed since start |
| rx_count | output | LEN_W | Bytes stored since start |
| done | output | 1 | Transfer complete pulse |

## Verification
The bench sweeps every word-size mode against every pair of transmit and receive lengths from 0 to 9. The cases fall into four groups:
- Equal lengths exercise the plain pack and unpack paths.
- A longer receive length forces zero filler words on transmit.
- A longer transmit length forces trimming of received bytes.
- A zero length in either direction reaches the N = 0 and pure-padding corners.

The automatic mode, run over lengths such as 4 and 8 against 0, 3 and 9, tells the multiple-of-4 selection apart from the 1-byte fallback. Valid and ready patterns that differ per transfer stall each handshake in different phases. Reprogramming the inputs and pulsing start during a run show whether a transfer ignores both.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;

    typedef enum logic [1:0] {
        WM_BYTE = 2'd0,
        WM_HALF = 2'd1,
        WM_FULL = 2'd2,
        WM_AUTO = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        TXS_IDLE,
        TXS_GATHER,
        TXS_EMIT
    } tx_state_e;

    typedef enum logic [1:0] {
        RXS_IDLE,
        RXS_WAIT,
        RXS_DRAIN
    } rx_state_e;

    typedef enum logic {
        TOP_IDLE,
        TOP_RUN
    } top_state_e;

endpackage

// File: rtl/spi_tx_packer.sv
module spi_tx_packer
    import spi_pack_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int WORD_W = 32,
    parameter int LG_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [LG_W-1:0]   go_lg,
    input  logic [LEN_W-1:0]  go_len,
    input  logic [LEN_W-1:0]  go_words,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              byte_ready,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    input  logic              word_ready,
    output logic              busy,
    output logic [LEN_W-1:0]  byte_cnt
);
    localparam int NB     = WORD_W / 8;
    localparam int SLOT_W = $clog2(NB);

    tx_state_e          st, st_n;
    logic [LG_W-1:0]    lg_q;
    logic [LEN_W-1:0]   left_q;
    logic [LEN_W-1:0]   words_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [SLOT_W-1:0]  last_slot;
    logic [WORD_W-1:0]  acc_q;
    logic               byte_fire;
    logic               word_fire;

    assign last_slot = SLOT_W'((1 << lg_q) - 1);
    assign byte_fire = byte_ready && byte_valid;
    assign word_fire = word_valid && word_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TXS_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            TXS_IDLE: begin
                if (go && (go_words != '0)) st_n = TXS_GATHER;
            end
            TXS_GATHER: begin
                if (left_q == '0)                             st_n = TXS_EMIT;
                else if (byte_valid && (slot_q == last_slot)) st_n = TXS_EMIT;
            end
            TXS_EMIT: begin
                if (word_ready)
                    st_n = (words_q == LEN_W'(1)) ? TXS_IDLE : TXS_GATHER;
            end
            default: st_n = TXS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        byte_ready = 1'b0;
        word_valid = 1'b0;
        busy       = 1'b1;
        unique case (st)
            TXS_IDLE:   busy       = 1'b0;
            TXS_GATHER: byte_ready = (left_q != '0);
            TXS_EMIT:   word_valid = 1'b1;
            default:    busy       = 1'b0;
        endcase
    end

    assign word_data = acc_q;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lg_q     <= '0;
            left_q   <= '0;
            words_q  <= '0;
            slot_q   <= '0;
            acc_q    <= '0;
            byte_cnt <= '0;
        end else if (go && (st == TXS_IDLE)) begin
            lg_q     <= go_lg;
            left_q   <= go_len;
            words_q  <= go_words;
            slot_q   <= '0;
            acc_q    <= '0;
            byte_cnt <= '0;
        end else begin
            if (byte_fire) begin
                for (int k = 0; k < NB; k++) begin
                    if (slot_q == SLOT_W'(k))
                        acc_q[(NB-1-k)*8 +: 8] <= byte_data;
                end
                slot_q   <= slot_q + 1'b1;
                left_q   <= left_q - 1'b1;
                byte_cnt <= byte_cnt + 1'b1;
            end
            if (word_fire) begin
                acc_q   <= '0;
                slot_q  <= '0;
                words_q <= words_q - 1'b1;
            end
        end
    end

    // R10
    txw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && !word_ready |=> word_valid && $stable(word_data));

    // R8
    tx_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cnt == $past(byte_cnt)) || (byte_cnt == $past(byte_cnt) + 1'b1)
        || (byte_cnt == '0));

endmodule

// File: rtl/spi_rx_unpacker.sv
module spi_rx_unpacker
    import spi_pack_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int WORD_W = 32,
    parameter int LG_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [LG_W-1:0]   go_lg,
    input  logic [LEN_W-1:0]  go_len,
    input  logic [LEN_W-1:0]  go_words,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    input  logic              byte_ready,
    output logic              busy,
    output logic [LEN_W-1:0]  byte_cnt
);
    localparam int NB     = WORD_W / 8;
    localparam int SLOT_W = $clog2(NB);

    rx_state_e          st, st_n;
    logic [LG_W-1:0]    lg_q;
    logic [LEN_W-1:0]   left_q;
    logic [LEN_W-1:0]   words_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [SLOT_W-1:0]  last_slot;
    logic [SLOT_W-1:0]  lane;
    logic [WORD_W-1:0]  word_q;
    logic               byte_fire;
    logic               word_fire;
    logic               drain_end;

    assign last_slot = SLOT_W'((1 << lg_q) - 1);
    assign lane      = last_slot - slot_q;
    assign byte_fire = byte_valid && byte_ready;
    assign word_fire = word_valid && word_ready;
    assign drain_end = (st == RXS_DRAIN) &&
                       ((left_q == '0) || (byte_ready && (slot_q == last_slot)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RXS_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            RXS_IDLE: begin
                if (go && (go_words != '0)) st_n = RXS_WAIT;
            end
            RXS_WAIT: begin
                if (word_valid) st_n = RXS_DRAIN;
            end
            RXS_DRAIN: begin
                if (drain_end)
                    st_n = (words_q == LEN_W'(1)) ? RXS_IDLE : RXS_WAIT;
            end
            default: st_n = RXS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        word_ready = 1'b0;
        byte_valid = 1'b0;
        busy       = 1'b1;
        unique case (st)
            RXS_IDLE:  busy       = 1'b0;
            RXS_WAIT:  word_ready = 1'b1;
            RXS_DRAIN: byte_valid = (left_q != '0);
            default:   busy       = 1'b0;
        endcase
    end

    always_comb begin
        byte_data = '0;
        for (int k = 0; k < NB; k++) begin
            if (lane == SLOT_W'(k)) byte_data = word_q[k*8 +: 8];
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lg_q     <= '0;
            left_q   <= '0;
            words_q  <= '0;
            slot_q   <= '0;
            word_q   <= '0;
            byte_cnt <= '0;
        end else if (go && (st == RXS_IDLE)) begin
            lg_q     <= go_lg;
            left_q   <= go_len;
            words_q  <= go_words;
            slot_q   <= '0;
            byte_cnt <= '0;
        end else begin
            if (word_fire) begin
                word_q <= word_data;
                slot_q <= '0;
            end
            if (byte_fire) begin
                slot_q   <= slot_q + 1'b1;
                left_q   <= left_q - 1'b1;
                byte_cnt <= byte_cnt + 1'b1;
            end
            if (drain_end) words_q <= words_q - 1'b1;
        end
    end

    // R10
    rxb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && !byte_ready |=> byte_valid && $stable(byte_data));

    // R8
    rx_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cnt == $past(byte_cnt)) || (byte_cnt == $past(byte_cnt) + 1'b1)
        || (byte_cnt == '0));

endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer
    import spi_pack_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int WORD_W = 32,
    parameter int BPW_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cfg_wmode,
    input  logic [LEN_W-1:0]  cfg_tx_len,
    input  logic [LEN_W-1:0]  cfg_rx_len,
    input  logic              tx_byte_valid,
    input  logic [7:0]        tx_byte_data,
    output logic              tx_byte_ready,
    output logic              tx_word_valid,
    output logic [WORD_W-1:0] tx_word_data,
    input  logic              tx_word_ready,
    input  logic              rx_word_valid,
    input  logic [WORD_W-1:0] rx_word_data,
    output logic              rx_word_ready,
    output logic              rx_byte_valid,
    output logic [7:0]        rx_byte_data,
    input  logic              rx_byte_ready,
    output logic [BPW_W-1:0]  bpw_code,
    output logic [LEN_W-1:0]  tx_count,
    output logic [LEN_W-1:0]  rx_count,
    output logic              done
);
    localparam int NB     = WORD_W / 8;
    localparam int LG_MAX = $clog2(NB);
    localparam int LG_W   = $clog2(LG_MAX + 1);

    top_state_e        st, st_n;
    wmode_e            mode;
    logic              go;
    logic [LG_W-1:0]   lg_sel;
    logic [LEN_W-1:0]  longest;
    logic [LEN_W:0]    rounded;
    logic [LEN_W-1:0]  words;
    logic              tx_busy;
    logic              rx_busy;

    assign mode = wmode_e'(cfg_wmode);
    assign go   = start && (st == TOP_IDLE);

    // word size selection
    always_comb begin
        unique case (mode)
            WM_BYTE: lg_sel = '0;
            WM_HALF: lg_sel = LG_W'(1);
            WM_FULL: lg_sel = LG_W'(LG_MAX);
            WM_AUTO: lg_sel = ((cfg_tx_len != '0) && (cfg_tx_len[LG_MAX-1:0] == '0))
                              ? LG_W'(LG_MAX) : '0;
            default: lg_sel = '0;
        endcase
    end

    assign longest = (cfg_tx_len > cfg_rx_len) ? cfg_tx_len : cfg_rx_len;
    assign rounded = {1'b0, longest} + (LEN_W+1)'((1 << lg_sel) - 1);
    assign words   = LEN_W'(rounded >> lg_sel);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TOP_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            TOP_IDLE: if (start) st_n = TOP_RUN;
            TOP_RUN:  if (!tx_busy && !rx_busy) st_n = TOP_IDLE;
            default:  st_n = TOP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        done = 1'b0;
        unique case (st)
            TOP_IDLE: done = 1'b0;
            TOP_RUN:  done = !tx_busy && !rx_busy;
            default:  done = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bpw_code <= BPW_W'(7);
        else if (go) bpw_code <= BPW_W'((8 << lg_sel) - 1);
    end

    spi_tx_packer #(.LEN_W(LEN_W), .WORD_W(WORD_W), .LG_W(LG_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .go_lg      (lg_sel),
        .go_len     (cfg_tx_len),
        .go_words   (words),
        .byte_valid (tx_byte_valid),
        .byte_data  (tx_byte_data),
        .byte_ready (tx_byte_ready),
        .word_valid (tx_word_valid),
        .word_data  (tx_word_data),
        .word_ready (tx_word_ready),
        .busy       (tx_busy),
        .byte_cnt   (tx_count)
    );

    spi_rx_unpacker #(.LEN_W(LEN_W), .WORD_W(WORD_W), .LG_W(LG_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .go_lg      (lg_sel),
        .go_len     (cfg_rx_len),
        .go_words   (words),
        .word_valid (rx_word_valid),
        .word_data  (rx_word_data),
        .word_ready (rx_word_ready),
        .byte_valid (rx_byte_valid),
        .byte_data  (rx_byte_data),
        .byte_ready (rx_byte_ready),
        .busy       (rx_busy),
        .byte_cnt   (rx_count)
    );

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    bpw_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({1'b0, bpw_code} + 1'b1) == 1) && (bpw_code >= BPW_W'(7)));

endmodule

// File: tb/spi_word_packer_bench.sv
module spi_word_packer_bench;
    localparam int LEN_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cfg_wmode = '0;
    logic [LEN_W-1:0] cfg_tx_len = '0;
    logic [LEN_W-1:0] cfg_rx_len = '0;
    logic        tx_byte_valid = 1'b0;
    logic [7:0]  tx_byte_data = '0;
    logic        tx_byte_ready;
    logic        tx_word_valid;
    logic [31:0] tx_word_data;
    logic        tx_word_ready = 1'b0;
    logic        rx_word_valid = 1'b0;
    logic [31:0] rx_word_data = '0;
    logic        rx_word_ready;
    logic        rx_byte_valid;
    logic [7:0]  rx_byte_data;
    logic        rx_byte_ready = 1'b0;
    logic [4:0]  bpw_code;
    logic [LEN_W-1:0] tx_count;
    logic [LEN_W-1:0] rx_count;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    spi_word_packer u_spi_word_packer (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_wmode(cfg_wmode),
        .cfg_tx_len(cfg_tx_len), .cfg_rx_len(cfg_rx_len),
        .tx_byte_valid(tx_byte_valid), .tx_byte_data(tx_byte_data),
        .tx_byte_ready(tx_byte_ready), .tx_word_valid(tx_word_valid),
        .tx_word_data(tx_word_data), .tx_word_ready(tx_word_ready),
        .rx_word_valid(rx_word_valid), .rx_word_data(rx_word_data),
        .rx_word_ready(rx_word_ready), .rx_byte_valid(rx_byte_valid),
        .rx_byte_data(rx_byte_data), .rx_byte_ready(rx_byte_ready),
        .bpw_code(bpw_code), .tx_count(tx_count), .rx_count(rx_count),
        .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] tx_pat(int t, int i);
        return 8'(t * 37 + i * 11 + 5);
    endfunction

    function automatic logic [31:0] rx_pat(int t, int w);
        return {8'(8'hA0 + w), 8'(t), 8'(w * 13 + 3), 8'(t * 5 + w * 3 + 1)};
    endfunction

    task automatic run_xfer(input int t, input int mode, input int txl, input int rxl);
        int lg;
        int ws;
        int nw;
        int txi;
        int txw;
        int rxw;
        int rxb;
        int n;
        bit seen;
        bit hold_pend;
        logic [31:0] hold_data;
        logic [31:0] exp_w;
        logic [7:0]  exp_b;
        // R1: mode 0/1/2 fixed sizes, 3 picks 4 bytes on nonzero multiple of 4
        if (mode == 3) lg = ((txl != 0) && (txl % 4 == 0)) ? 2 : 0;
        else           lg = mode;
        ws = 1 << lg;
        nw = (((txl > rxl) ? txl : rxl) + ws - 1) / ws;
        txi = 0; txw = 0; rxw = 0; rxb = 0; n = 0;
        seen = 1'b0; hold_pend = 1'b0; hold_data = '0;

        @(negedge clk);
        cfg_wmode  = 2'(mode);
        cfg_tx_len = LEN_W'(txl);
        cfg_rx_len = LEN_W'(rxl);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cfg_wmode  = 2'(mode ^ 1);
        cfg_tx_len = LEN_W'(txl + 5);
        cfg_rx_len = LEN_W'(rxl + 3);
        chk(bpw_code == 5'(ws * 8 - 1), "R1/R2 bpw code", bpw_code, ws * 8 - 1);

        while (!seen && n < 600) begin
            if (n > 0) @(negedge clk);
            n = n + 1;
            if (done) begin
                seen = 1'b1;
                tx_byte_valid = 1'b0;
                tx_word_ready = 1'b0;
                rx_word_valid = 1'b0;
                rx_byte_ready = 1'b0;
                break;
            end
            // R7: stray start while running
            start = (n == 3);
            // byte source
            tx_byte_valid = ((t + n) % 5 != 3);
            tx_byte_data  = tx_pat(t, txi);
            if (tx_byte_valid && tx_byte_ready) txi = txi + 1;
            // word sink
            if (hold_pend)
                chk(tx_word_valid && tx_word_data == hold_data, "R10 tx word held",
                    tx_word_data, hold_data);
            tx_word_ready = ((t + n) % 3 != 1);
            if (tx_word_valid) begin
                if (tx_word_ready) begin
                    exp_w = '0;
                    for (int k = 0; k < ws; k++) begin
                        if (txw * ws + k < txl)
                            exp_w[8*(3-k) +: 8] = tx_pat(t, txw * ws + k);
                    end
                    chk(tx_word_data == exp_w, "R3/R4 tx word", tx_word_data, exp_w);
                    txw = txw + 1;
                    hold_pend = 1'b0;
                end else begin
                    hold_pend = 1'b1;
                    hold_data = tx_word_data;
                end
            end else begin
                hold_pend = 1'b0;
            end
            // word source
            rx_word_valid = ((t + n) % 2 == 0);
            rx_word_data  = rx_pat(t, rxw);
            if (rx_word_valid && rx_word_ready) rxw = rxw + 1;
            // byte sink
            rx_byte_ready = ((t + n) % 4 != 2);
            if (rx_byte_valid && rx_byte_ready) begin
                exp_b = 8'(rx_pat(t, rxb / ws) >> (8 * (ws - 1 - (rxb % ws))));
                chk((rxb < rxl) && rx_byte_data == exp_b, "R5/R6 rx byte",
                    rx_byte_data, exp_b);
                rxb = rxb + 1;
            end
        end
        start = 1'b0;
        chk(seen, "R9 done reached", seen, 1);
        chk(txw == nw, "R1/R4 tx word count", txw, nw);
        chk(rxw == nw, "R6 rx words consumed", rxw, nw);
        chk(rxb == rxl, "R6 rx bytes stored", rxb, rxl);
        chk(tx_count == LEN_W'(txl), "R8 tx_count", tx_count, txl);
        chk(rx_count == LEN_W'(rxl), "R8 rx_count", rx_count, rxl);
        chk(bpw_code == 5'(ws * 8 - 1), "R7 bpw unchanged", bpw_code, ws * 8 - 1);
        @(negedge clk);
        chk(!done, "R9 done single cycle", done, 0);
    endtask

    initial begin
        int t;
        t = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bpw_code == 5'd7, "R2 reset bpw", bpw_code, 7);
        chk(!done, "R9 reset done", done, 0);
        chk(!tx_word_valid && !tx_byte_ready, "R4 reset tx idle",
            {tx_word_valid, tx_byte_ready}, 0);
        chk(!rx_byte_valid && !rx_word_ready, "R6 reset rx idle",
            {rx_byte_valid, rx_word_ready}, 0);
        chk(tx_count == '0 && rx_count == '0, "R8 reset counts",
            {tx_count, rx_count}, 0);
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 10; a++) begin
                for (int b = 0; b < 10; b++) begin
                    run_xfer(t, m, a, b);
                    t = t + 1;
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule